// File: doc/BRIEF.md
# Dual-Bank Steered Display Timing Register File

This block holds the timing and hardware-cursor registers for two display controllers behind one index/data port pair of the classic VGA kind. Software writes an 8-bit index through the index port, then reads or writes the selected register through the data port. Every index in the timing range and in the cursor range has two physical copies, one per controller. A separate steering register picks which copy a read returns and which copies a write updates.

Read steering and write steering are independent. One write can land in both banks at once, so the second controller mirrors the first. Software can also copy one bank into the other: it reads from bank 1 and writes the same value back to bank 2 only. A separate range of indices holds single shared registers that ignore the steering. One of them carries the two cursor enables. Both banks and the shared registers are exported in parallel, so two timing generators can use them at the same time.

Top module: `dual_timing_regfile`

## Requirements
- R1: After reset the steering register reads 0x40, the latched index reads 0, and every banked and shared register holds zero.
- R2: A write on port select 0 latches the index, and reading port select 0 returns it. Data-port accesses (select 1) use the most recently latched index. Select 2 is the steering register. Select 3 reads zero.
- R3: A data write to a paired index updates bank 1 when steering bit 3 is clear. It leaves bank 1 unchanged when bit 3 is set.
- R4: A data write to a paired index updates bank 2 when steering bit 2 is set. It leaves bank 2 unchanged when bit 2 is clear.
- R5: A data read from a paired index returns bank 2 when steering bit 0 or bit 1 is set, and bank 1 otherwise.
- R6: With bit 2 set and bit 3 clear (for example 0x44 or 0x47), a single data write updates both banks with the same value.
- R7: Indices 0x30..0x45 are shared single registers. They are written and read the same way whatever the steering value.
- R8: Indices outside 0x00..0x18, 0x30..0x45 and 0x46..0x4F read back zero. Writes to them change no register.
- R9: Cursor indices 0x46..0x4F are paired and steered exactly like the timing indices 0x00..0x18.
- R10: In shared register 0x45, bit 0 drives `cursor1_en` and bit 2 drives `cursor2_en`.
- R11: The bank outputs place slot k at bits [8k+7:8k]. Slots 0..24 are indices 0x00..0x18, and slots 25..34 are indices 0x46..0x4F. Shared slot k is index 0x30+k.
- R12: With steering 0x4C, a data read returns bank 1 and a data write updates only bank 2, so reading and then writing back copies a register from bank 1 to bank 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | 0 index, 1 data, 2 steering, 3 none |
| bus_we | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the selected port |
| bank1_regs | output | 280 | All bank 1 registers, slot ordered |
| bank2_regs | output | 280 | All bank 2 registers, slot ordered |
| shared_regs | output | 176 | All shared registers, slot ordered |
| cursor1_en | output | 1 | Cursor 1 enable |
| cursor2_en | output | 1 | Cursor 2 enable |

## Verification
The bench covers the steering values that split reads from writes: 0x4C, 0x48 and the single-bit read selects 0x41 and 0x42. A design that decodes only one read bit, or ties reads to the write enables, returns the wrong bank there. It writes to unmapped indices and compares the full exported vectors before and after, which catches a decoder that aliases a stray index onto a real slot. It also checks the last timing slot and the last cursor slot, where an off-by-one slot map would overwrite a neighbour or drop the write.

// File: rtl/dual_timing_regfile.sv
module dual_timing_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter logic [IDX_W-1:0] TIM_FIRST  = 8'h00,
  parameter logic [IDX_W-1:0] TIM_LAST   = 8'h18,
  parameter logic [IDX_W-1:0] CUR_FIRST  = 8'h46,
  parameter logic [IDX_W-1:0] CUR_LAST   = 8'h4F,
  parameter logic [IDX_W-1:0] SHR_FIRST  = 8'h30,
  parameter logic [IDX_W-1:0] SHR_LAST   = 8'h45,
  parameter logic [IDX_W-1:0] CUR_EN_IDX = 8'h45,
  parameter logic [DATA_W-1:0] STEER_RST = 8'h40,
  localparam int NTIM  = int'(TIM_LAST) - int'(TIM_FIRST) + 1,
  localparam int NCUR  = int'(CUR_LAST) - int'(CUR_FIRST) + 1,
  localparam int NPAIR = NTIM + NCUR,
  localparam int NSHR  = int'(SHR_LAST) - int'(SHR_FIRST) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bus_sel,
  input  logic                    bus_we,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [NPAIR*DATA_W-1:0] bank1_regs,
  output logic [NPAIR*DATA_W-1:0] bank2_regs,
  output logic [NSHR*DATA_W-1:0]  shared_regs,
  output logic                    cursor1_en,
  output logic                    cursor2_en
);
  localparam int PW  = $clog2(NPAIR);
  localparam int SW  = $clog2(NSHR);
  localparam int CEN = int'(CUR_EN_IDX) - int'(SHR_FIRST);
  localparam logic [1:0] SEL_IDX = 2'd0, SEL_DAT = 2'd1, SEL_STR = 2'd2;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] steer_q;
  logic [DATA_W-1:0] b1 [NPAIR];
  logic [DATA_W-1:0] b2 [NPAIR];
  logic [DATA_W-1:0] sh [NSHR];

  wire wr_idx = bus_we && bus_sel == SEL_IDX;
  wire wr_dat = bus_we && bus_sel == SEL_DAT;
  wire wr_str = bus_we && bus_sel == SEL_STR;

  wire tim_hit  = idx_q >= TIM_FIRST && idx_q <= TIM_LAST;
  wire cur_hit  = idx_q >= CUR_FIRST && idx_q <= CUR_LAST;
  wire shr_hit  = idx_q >= SHR_FIRST && idx_q <= SHR_LAST;
  wire pair_hit = tim_hit || cur_hit;

  wire [PW-1:0] pslot = tim_hit ? PW'(idx_q - TIM_FIRST)
                                : PW'(idx_q - CUR_FIRST) + PW'(NTIM);
  wire [SW-1:0] sslot = SW'(idx_q - SHR_FIRST);

  wire b1_we  = wr_dat && pair_hit && !steer_q[3];
  wire b2_we  = wr_dat && pair_hit && steer_q[2];
  wire sh_we  = wr_dat && shr_hit;
  wire rd_b2  = |steer_q[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      steer_q <= STEER_RST;
      for (int i = 0; i < NPAIR; i++) begin
        b1[i] <= '0;
        b2[i] <= '0;
      end
      for (int i = 0; i < NSHR; i++) sh[i] <= '0;
    end else begin
      if (wr_idx) idx_q <= bus_wdata[IDX_W-1:0];
      if (wr_str) steer_q <= bus_wdata;
      if (b1_we) b1[pslot] <= bus_wdata;
      if (b2_we) b2[pslot] <= bus_wdata;
      if (sh_we) sh[sslot] <= bus_wdata;
    end
  end

  logic [DATA_W-1:0] dat_rd;
  always_comb begin
    if (pair_hit)     dat_rd = rd_b2 ? b2[pslot] : b1[pslot];
    else if (shr_hit) dat_rd = sh[sslot];
    else              dat_rd = '0;
  end

  always_comb begin
    case (bus_sel)
      SEL_IDX: bus_rdata = DATA_W'(idx_q);
      SEL_DAT: bus_rdata = dat_rd;
      SEL_STR: bus_rdata = steer_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign bank1_regs[g*DATA_W +: DATA_W] = b1[g];
    assign bank2_regs[g*DATA_W +: DATA_W] = b2[g];
  end
  for (genvar g = 0; g < NSHR; g++) begin : g_shr
    assign shared_regs[g*DATA_W +: DATA_W] = sh[g];
  end

  assign cursor1_en = sh[CEN][0];
  assign cursor2_en = sh[CEN][2];

  a_r3_bank1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat && steer_q[3] |=> $stable(bank1_regs));
  a_r4_bank2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat && !steer_q[2] |=> $stable(bank2_regs));
  a_r7_shared_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dat && shr_hit) |=> $stable(shared_regs));
  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_idx |=> $stable(idx_q));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == SEL_DAT && !pair_hit && !shr_hit |-> bus_rdata == '0);
endmodule

// File: tb/dual_timing_regfile_tb_top.sv
module dual_timing_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [279:0] bank1_regs, bank2_regs;
  logic [175:0] shared_regs;
  logic cursor1_en, cursor2_en;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_timing_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bank1_regs(bank1_regs), .bank2_regs(bank2_regs),
    .shared_regs(shared_regs), .cursor1_en(cursor1_en), .cursor2_en(cursor2_en));

  // steer, index, data, expected bank1, expected bank2
  localparam logic [39:0] VEC [8] = '{
    {8'h40, 8'h05, 8'hA1, 8'hA1, 8'h00},
    {8'h4F, 8'h06, 8'hB2, 8'h00, 8'hB2},
    {8'h44, 8'h07, 8'hC3, 8'hC3, 8'hC3},
    {8'h4C, 8'h08, 8'hD4, 8'h00, 8'hD4},
    {8'h48, 8'h09, 8'hE5, 8'h00, 8'h00},
    {8'h40, 8'h46, 8'h11, 8'h11, 8'h00},
    {8'h47, 8'h4F, 8'h22, 8'h22, 8'h22},
    {8'h4F, 8'h18, 8'h33, 8'h00, 8'h33}
  };

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] q);
    bus_sel = s; bus_we = 1'b0;
    #1 q = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [279:0] act, input logic [279:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_at(input logic [7:0] steer, input logic [7:0] idx, output logic [7:0] q);
    wr(2'd2, steer);
    wr(2'd0, idx);
    rd(2'd1, q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, q2;
    logic [279:0] s1, s2;
    logic [175:0] ss;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd2, q); chk("R1 steer", q, 8'h40);
    rd(2'd0, q); chk("R1 index", q, 8'h00);
    chk("R1 bank1", bank1_regs, '0);
    chk("R1 bank2", bank2_regs, '0);
    chk("R1 shared", {104'h0, shared_regs}, '0);

    for (int i = 0; i < 8; i++) begin
      wr(2'd2, VEC[i][39:32]);
      wr(2'd0, VEC[i][31:24]);
      wr(2'd1, VEC[i][23:16]);
      rd_at(8'h40, VEC[i][31:24], q);
      chk($sformatf("R3 R6 R9 row %0d bank1", i), q, VEC[i][15:8]);
      rd_at(8'h4F, VEC[i][31:24], q);
      chk($sformatf("R4 R6 R9 row %0d bank2", i), q, VEC[i][7:0]);
    end

    wr(2'd0, 8'h07); rd(2'd0, q); chk("R2 index readback", q, 8'h07);
    rd(2'd3, q); chk("R2 select 3 zero", q, 8'h00);

    rd_at(8'h41, 8'h06, q); chk("R5 bit0 reads bank2", q, 8'hB2);
    rd_at(8'h42, 8'h06, q); chk("R5 bit1 reads bank2", q, 8'hB2);
    rd_at(8'h40, 8'h06, q); chk("R5 clear reads bank1", q, 8'h00);

    rd_at(8'h4C, 8'h05, q); chk("R12 copy read bank1", q, 8'hA1);
    wr(2'd1, q);
    rd_at(8'h4F, 8'h05, q2); chk("R12 copy into bank2", q2, 8'hA1);
    rd_at(8'h40, 8'h05, q2); chk("R12 bank1 kept", q2, 8'hA1);

    wr(2'd2, 8'h4F); wr(2'd0, 8'h30); wr(2'd1, 8'h5A);
    rd_at(8'h40, 8'h30, q); chk("R7 shared under 0x40", q, 8'h5A);
    wr(2'd2, 8'h48); wr(2'd0, 8'h31); wr(2'd1, 8'h66);
    rd_at(8'h4F, 8'h31, q); chk("R7 shared under 0x4F", q, 8'h66);

    s1 = bank1_regs; s2 = bank2_regs; ss = shared_regs;
    wr(2'd2, 8'h44);
    wr(2'd0, 8'h20); wr(2'd1, 8'h77); rd(2'd1, q); chk("R8 unmapped 0x20 zero", q, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h78); rd(2'd1, q); chk("R8 unmapped 0xFF zero", q, 8'h00);
    wr(2'd0, 8'h19); wr(2'd1, 8'h79); rd(2'd1, q); chk("R8 unmapped 0x19 zero", q, 8'h00);
    chk("R8 bank1 untouched", bank1_regs, s1);
    chk("R8 bank2 untouched", bank2_regs, s2);
    chk("R8 shared untouched", {104'h0, shared_regs}, {104'h0, ss});

    wr(2'd2, 8'h40); wr(2'd0, 8'h45); wr(2'd1, 8'h05);
    chk("R10 both cursors on", {278'h0, cursor1_en, cursor2_en}, 280'h3);
    wr(2'd1, 8'h04);
    chk("R10 cursor2 only", {278'h0, cursor1_en, cursor2_en}, 280'h1);

    chk("R11 bank1 slot 5", {272'h0, bank1_regs[5*8 +: 8]}, 280'hA1);
    chk("R11 bank2 slot 24", {272'h0, bank2_regs[24*8 +: 8]}, 280'h33);
    chk("R11 bank2 slot 34", {272'h0, bank2_regs[34*8 +: 8]}, 280'h22);
    chk("R11 bank1 slot 25", {272'h0, bank1_regs[25*8 +: 8]}, 280'h11);
    chk("R11 shared slot 0", {272'h0, shared_regs[7:0]}, 280'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule